// File: doc/BRIEF.md
# Load-reserved / store-conditional reservation monitor

This block sits between one hart's load/store pipeline and a word-addressed data memory. It carries out load-reserved and store-conditional operations on 32-bit words. It decodes the atomic instruction word and keeps a single reservation for the hart. It decides whether each conditional store may reach memory and returns the result value for the destination register. A snoop port reports writes made by other agents, and any such write that lands in the reserved granule breaks the reservation.

The reservation is a valid bit plus the tag of one naturally aligned granule of `GRAN_BYTES` bytes (16 by default). A load-reserved reads the word, sign-extends it to `XLEN` bits and reserves its granule, replacing any earlier reservation. A store-conditional writes only when the reservation is valid, its target lies in the reserved granule, and the target is outside the non-eventual address window. On success it returns 0. On failure it returns 1 and does not touch memory. Either way, the store-conditional drops the reservation. The acquire and release ordering bits are exported but are not enforced.

The sequencer has three states. `ST_IDLE` accepts an instruction when `instr_valid` is high and moves to `ST_ISSUE` (transition *accept*). `ST_ISSUE` drives the memory request and updates the reservation, then always moves to `ST_RESP` (transition *issue*). `ST_RESP` presents the result, then always returns to `ST_IDLE` (transition *retire*). Each operation therefore occupies exactly two cycles after the accept edge. `instr_valid` is ignored while the block is busy.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset, `busy`, `mem_req` and `done` are low and no reservation is held, so a store-conditional issued first fails with `rd_data` = 1.
- R2: An instruction accepted on a clock edge while idle raises `busy` and drives any memory request in the next cycle (`done` low). `done` is high in the cycle after that, with `rd_idx` = instr[11:7]. `busy` is low in the cycle that follows.
- R3: Load-reserved (opcode instr[6:0] = 0101111, funct5 instr[31:27] = 00010, funct3 instr[14:12] = 010, instr[24:20] = 0) issues a read of word address `rs1_addr[AW-1:2]` and returns the memory word sign-extended from bit 31 to `XLEN` bits, with `rd_we` high.
- R4: Store-conditional (funct5 = 00011, funct3 = 010) succeeds when a reservation is valid and `rs1_addr[AW-1:log2(GRAN_BYTES)]` equals the reserved tag. It then issues a write of `rs2_data` (`mem_req` and `mem_we` high) and returns `rd_data` = 0.
- R5: A failing store-conditional issues no memory request, leaves memory unchanged and returns `rd_data` = 1.
- R6: Every store-conditional, whether it succeeds or fails, clears the reservation.
- R7: A load-reserved replaces any earlier reservation with its own granule.
- R8: A snoop write (`snoop_valid`) whose address falls in the reserved granule clears the reservation on the next edge. A snoop to another granule has no effect. A snoop to the new granule during a load-reserved's issue cycle leaves no reservation.
- R9: A store-conditional whose address matches the non-eventual window (`(rs1_addr & NONEV_MASK) == NONEV_BASE`, default top nibble F) always fails.
- R10: An instruction with a wrong opcode, an unknown funct5, funct3 ≠ 010, or a load-reserved with nonzero instr[24:20] completes with `illegal` high and `rd_we` low. It makes no memory request and leaves the reservation unchanged.
- R11: `ord_aq` and `ord_rl` equal instr[26] and instr[25] of the accepted instruction while `busy` is high, and are low while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid (accepted only when idle) |
| instr | input | 32 | Atomic instruction word |
| rs1_addr | input | AW | Byte address from rs1 |
| rs2_data | input | 32 | Store data from rs2 |
| snoop_valid | input | 1 | External write observed this cycle |
| snoop_addr | input | AW | Byte address of the external write |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW-2 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid this cycle |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register value |
| illegal | output | 1 | Accepted instruction was illegal |
| ord_aq | output | 1 | Acquire bit of the current operation |
| ord_rl | output | 1 | Release bit of the current operation |

## Verification
The bench builds the monitor with `XLEN` = 64. This makes the sign extension of a loaded word with bit 31 set visible in the upper half of `rd_data`, next to a positive word that must come back zero-extended. The granule size (16 bytes) and the non-eventual window (addresses with the top nibble F) keep their defaults. With these values the bench can hit the same-granule and neighbouring-granule store cases at 0x4C and 0x50 against a reservation at 0x40. It also checks the forced failure at 0xF000_0040 against the same word offset.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    localparam logic [6:0] OPC_ATOMIC   = 7'b0101111;
    localparam logic [4:0] F5_LOADRES   = 5'b00010;
    localparam logic [4:0] F5_STORECOND = 5'b00011;
    localparam logic [2:0] F3_WORD      = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LR   = 2'd1,
        OP_SC   = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       aq;
        logic       rl;
        logic [4:0] rd;
        logic       bad;
    } dec_t;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [4:0] f5;
    logic [4:0] src2;
    logic [2:0] f3;
    logic [6:0] opc;
    logic       unused_addr_field;

    assign unused_addr_field = ^instr[19:15];

    always_comb begin
        f5   = instr[31:27];
        src2 = instr[24:20];
        f3   = instr[14:12];
        opc  = instr[6:0];
        dec.aq = instr[26];
        dec.rl = instr[25];
        dec.rd = instr[11:7];
        if (f5 == F5_LOADRES) begin
            dec.kind = OP_LR;
        end else if (f5 == F5_STORECOND) begin
            dec.kind = OP_SC;
        end else begin
            dec.kind = OP_NONE;
        end
        dec.bad = (opc != OPC_ATOMIC) || (f3 != F3_WORD) || (dec.kind == OP_NONE)
                  || ((dec.kind == OP_LR) && (src2 != 5'd0));
    end
endmodule

// File: rtl/lrsc_region.sv
module lrsc_region #(
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   NONEV_MASK = 32'hF000_0000,
    parameter logic [AW-1:0]   NONEV_BASE = 32'hF000_0000
) (
    input  logic [AW-1:0] addr,
    output logic          eventual
);
    assign eventual = ((addr & NONEV_MASK) != NONEV_BASE);
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int TAGW = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic            clr,
    input  logic [TAGW-1:0] set_tag,
    input  logic            snoop_valid,
    input  logic [TAGW-1:0] snoop_tag,
    output logic            valid,
    output logic [TAGW-1:0] tag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
        end else if (set) begin
            tag   <= set_tag;
            valid <= !(snoop_valid && (snoop_tag == set_tag));
        end else if (clr) begin
            valid <= 1'b0;
        end else if (snoop_valid && (snoop_tag == tag)) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_seq.sv
module lrsc_seq
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 32,
    parameter int GB   = 4,
    localparam int TAGW = AW - GB,
    localparam int WAW  = AW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  dec_t            dec_in,
    input  logic [AW-1:0]   rs1_addr,
    input  logic [31:0]     rs2_data,
    input  logic            eventual,
    input  logic            resv_valid,
    input  logic [TAGW-1:0] resv_tag,
    input  logic [31:0]     mem_rdata,
    output logic [AW-1:0]   lat_addr,
    output logic            resv_set,
    output logic            resv_clr,
    output logic [TAGW-1:0] resv_tag_new,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WAW-1:0]  mem_addr,
    output logic [31:0]     mem_wdata,
    output logic            busy,
    output logic            done,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            ord_aq,
    output logic            ord_rl,
    output logic            op_is_sc
);
    seq_state_e      state, state_nx;
    dec_t            lat_dec;
    logic [31:0]     lat_data;
    logic            sc_ok, sc_ok_q;
    logic            is_lr, is_sc;
    logic [XLEN-1:0] ld_ext;
    logic            unused_low;

    assign unused_low = ^lat_addr[1:0];

    generate
        if (XLEN > 32) begin : g_sext
            assign ld_ext = {{(XLEN-32){mem_rdata[31]}}, mem_rdata};
        end else begin : g_same
            assign ld_ext = mem_rdata;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, issue, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (instr_valid) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // operand capture and decision capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_dec  <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            sc_ok_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && instr_valid) begin
                lat_dec  <= dec_in;
                lat_addr <= rs1_addr;
                lat_data <= rs2_data;
            end
            if (state == ST_ISSUE) sc_ok_q <= sc_ok;
        end
    end

    assign is_lr = (lat_dec.kind == OP_LR) && !lat_dec.bad;
    assign is_sc = (lat_dec.kind == OP_SC) && !lat_dec.bad;
    assign sc_ok = is_sc && resv_valid && eventual && (resv_tag == lat_addr[AW-1:GB]);

    // outputs
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = lat_addr[AW-1:2];
        mem_wdata    = lat_data;
        resv_set     = 1'b0;
        resv_clr     = 1'b0;
        resv_tag_new = lat_addr[AW-1:GB];
        busy         = 1'b0;
        done         = 1'b0;
        rd_we        = 1'b0;
        rd_idx       = lat_dec.rd;
        rd_data      = '0;
        illegal      = 1'b0;
        ord_aq       = 1'b0;
        ord_rl       = 1'b0;
        op_is_sc     = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                busy     = 1'b1;
                ord_aq   = lat_dec.aq;
                ord_rl   = lat_dec.rl;
                mem_req  = is_lr || sc_ok;
                mem_we   = sc_ok;
                resv_set = is_lr;
                resv_clr = is_sc;
            end
            ST_RESP: begin
                busy     = 1'b1;
                done     = 1'b1;
                ord_aq   = lat_dec.aq;
                ord_rl   = lat_dec.rl;
                illegal  = lat_dec.bad;
                rd_we    = !lat_dec.bad;
                op_is_sc = is_sc;
                if (is_lr)      rd_data = ld_ext;
                else if (is_sc) rd_data = sc_ok_q ? '0 : {{(XLEN-1){1'b0}}, 1'b1};
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int            XLEN       = 32,
    parameter int            AW         = 32,
    parameter int            GRAN_BYTES = 16,
    parameter logic [AW-1:0] NONEV_MASK = 32'hF000_0000,
    parameter logic [AW-1:0] NONEV_BASE = 32'hF000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [AW-1:0]   rs1_addr,
    input  logic [31:0]     rs2_data,
    input  logic            snoop_valid,
    input  logic [AW-1:0]   snoop_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-3:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            rd_we,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            ord_aq,
    output logic            ord_rl
);
    localparam int GB   = $clog2(GRAN_BYTES);
    localparam int TAGW = AW - GB;

    dec_t            dec;
    logic [AW-1:0]   lat_addr;
    logic            eventual;
    logic            resv_valid, resv_set, resv_clr;
    logic [TAGW-1:0] resv_tag, resv_tag_new, snoop_tag;
    logic            snoop_hit;
    logic            op_is_sc;
    logic            unused_snoop_low;

    assign snoop_tag        = snoop_addr[AW-1:GB];
    assign unused_snoop_low = ^snoop_addr[GB-1:0];
    assign snoop_hit        = snoop_valid && (snoop_tag == resv_tag);

    lrsc_decode u_dec (.instr(instr), .dec(dec));

    lrsc_region #(.AW(AW), .NONEV_MASK(NONEV_MASK), .NONEV_BASE(NONEV_BASE)) u_region (
        .addr(lat_addr), .eventual(eventual)
    );

    lrsc_resv #(.TAGW(TAGW)) u_resv (
        .clk(clk), .rst_n(rst_n), .set(resv_set), .clr(resv_clr), .set_tag(resv_tag_new),
        .snoop_valid(snoop_valid), .snoop_tag(snoop_tag), .valid(resv_valid), .tag(resv_tag)
    );

    lrsc_seq #(.XLEN(XLEN), .AW(AW), .GB(GB)) u_seq (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .dec_in(dec),
        .rs1_addr(rs1_addr), .rs2_data(rs2_data), .eventual(eventual),
        .resv_valid(resv_valid), .resv_tag(resv_tag), .mem_rdata(mem_rdata),
        .lat_addr(lat_addr), .resv_set(resv_set), .resv_clr(resv_clr),
        .resv_tag_new(resv_tag_new), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data), .illegal(illegal),
        .ord_aq(ord_aq), .ord_rl(ord_rl), .op_is_sc(op_is_sc)
    );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            busy,
    input logic            done,
    input logic            mem_req,
    input logic            mem_we,
    input logic            rd_we,
    input logic            illegal,
    input logic [XLEN-1:0] rd_data,
    input logic            ord_aq,
    input logic            ord_rl,
    input logic            resv_valid,
    input logic            resv_set,
    input logic            snoop_hit,
    input logic            op_is_sc
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    assert_accept_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid) |=> (busy && !done));

    assert_accept_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid) |=> ##1 done);

    assert_write_then_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (done && rd_data == '0));

    assert_fail_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_is_sc && rd_data != '0) |-> !$past(mem_req));

    assert_sc_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_is_sc) |-> !resv_valid);

    assert_snoop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && resv_valid && !resv_set) |=> !resv_valid);

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!rd_we && !$past(mem_req)));

    assert_order_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ord_aq && !ord_rl));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .rd_we(rd_we), .illegal(illegal),
    .rd_data(rd_data), .ord_aq(ord_aq), .ord_rl(ord_rl), .resv_valid(resv_valid),
    .resv_set(resv_set), .snoop_hit(snoop_hit), .op_is_sc(op_is_sc)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
    localparam int XLEN = 64;
    localparam int AW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            instr_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [AW-1:0]   rs1_addr = '0;
    logic [31:0]     rs2_data = '0;
    logic            snoop_valid = 1'b0;
    logic [AW-1:0]   snoop_addr = '0;
    logic            mem_req, mem_we;
    logic [AW-3:0]   mem_addr;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;
    logic            busy, done, rd_we, illegal, ord_aq, ord_rl;
    logic [4:0]      rd_idx;
    logic [XLEN-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] bmem [0:63];

    // captured values: issue cycle (c_*), result cycle (r_*), idle afterwards (i_*)
    logic        c_req, c_we, c_busy, c_done, c_aq, c_rl;
    logic [AW-3:0] c_addr;
    logic [31:0] c_wdata;
    logic        r_done, r_busy, r_we, r_ill;
    logic [4:0]  r_idx;
    logic [XLEN-1:0] r_data;
    logic        i_busy, i_aq, i_rl;

    always #5 clk = ~clk;

    lrsc_monitor #(.XLEN(XLEN), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_addr(rs1_addr), .rs2_data(rs2_data), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .illegal(illegal), .ord_aq(ord_aq), .ord_rl(ord_rl)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[5:0]];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq, input logic rl,
                                        input logic [4:0] s2, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
        return {f5, aq, rl, s2, 5'd10, f3, rd, opc};
    endfunction

    function automatic logic [31:0] lr_i(input logic [4:0] rd);
        return enc(5'b00010, 1'b0, 1'b0, 5'd0, 3'b010, rd, 7'b0101111);
    endfunction

    function automatic logic [31:0] sc_i(input logic [4:0] rd);
        return enc(5'b00011, 1'b0, 1'b0, 5'd7, 3'b010, rd, 7'b0101111);
    endfunction

    task automatic op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] d,
                      input bit sn_acc, input bit sn_iss, input logic [31:0] sa);
        @(negedge clk);
        instr_valid = 1'b1; instr = ins; rs1_addr = a; rs2_data = d;
        snoop_valid = sn_acc; snoop_addr = sa;
        @(negedge clk);
        instr_valid = 1'b0; snoop_valid = sn_iss; snoop_addr = sa;
        c_req = mem_req; c_we = mem_we; c_addr = mem_addr; c_wdata = mem_wdata;
        c_busy = busy; c_done = done; c_aq = ord_aq; c_rl = ord_rl;
        @(negedge clk);
        snoop_valid = 1'b0;
        r_done = done; r_busy = busy; r_we = rd_we; r_ill = illegal; r_idx = rd_idx; r_data = rd_data;
        @(negedge clk);
        i_busy = busy; i_aq = ord_aq; i_rl = ord_rl;
    endtask

    task automatic lr_at(input logic [31:0] a, input logic [4:0] rd);
        op(lr_i(rd), a, 32'h0, 0, 0, 32'h0);
    endtask

    task automatic sc_at(input logic [31:0] a, input logic [31:0] d, input logic [4:0] rd);
        op(sc_i(rd), a, d, 0, 0, 32'h0);
    endtask

    task automatic snoop(input logic [31:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic sc_expect(input string tag, input bit ok);
        chk({tag, " rd"}, r_data, ok ? 64'd0 : 64'd1);
        chk({tag, " req"}, {62'd0, c_req, c_we}, ok ? 64'd3 : 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy", {63'd0, busy}, 0);
        chk("R1 mem_req", {63'd0, mem_req}, 0);
        chk("R1 done", {63'd0, done}, 0);
        sc_at(32'h40, 32'h5555, 5'd3);
        sc_expect("R1 no reservation", 0);
    endtask

    task automatic t_load;
        lr_at(32'h40, 5'd5);
        chk("R2 issue busy/done", {62'd0, c_busy, c_done}, 64'd2);
        chk("R2 result busy/done", {62'd0, r_busy, r_done}, 64'd3);
        chk("R2 idle after", {63'd0, i_busy}, 0);
        chk("R2 rd_idx", {59'd0, r_idx}, 5);
        chk("R3 read req", {62'd0, c_req, c_we}, 64'd2);
        chk("R3 word addr", {34'd0, c_addr}, 64'h10);
        chk("R3 sign extend", r_data, 64'hFFFF_FFFF_8000_1234);
        chk("R3 rd_we", {63'd0, r_we}, 1);
    endtask

    task automatic t_store;
        sc_at(32'h40, 32'h0000_ABCD, 5'd6);
        sc_expect("R4 success", 1);
        chk("R4 wdata", {32'd0, c_wdata}, 64'hABCD);
        lr_at(32'h40, 5'd5);
        chk("R3 positive word", r_data, 64'h0000_0000_0000_ABCD);
        sc_at(32'h40, 32'h1111, 5'd6);
        sc_expect("R4 second success", 1);
        sc_at(32'h40, 32'h2222, 5'd6);
        sc_expect("R6 cleared after success", 0);
        lr_at(32'h40, 5'd5);
        chk("R5 memory untouched", r_data, 64'h1111);
    endtask

    task automatic t_granule;
        sc_at(32'h4C, 32'h3333, 5'd6);
        sc_expect("R4 same granule", 1);
        lr_at(32'h4C, 5'd5);
        chk("R4 granule write", r_data, 64'h3333);
        lr_at(32'h40, 5'd5);
        sc_at(32'h50, 32'h4444, 5'd6);
        sc_expect("R4 other granule fails", 0);
        sc_at(32'h40, 32'h4444, 5'd6);
        sc_expect("R6 cleared after failure", 0);
    endtask

    task automatic t_snoop;
        lr_at(32'h40, 5'd5);
        snoop(32'h48);
        sc_at(32'h40, 32'h5555, 5'd6);
        sc_expect("R8 overlapping snoop", 0);
        lr_at(32'h40, 5'd5);
        snoop(32'h80);
        sc_at(32'h40, 32'h6666, 5'd6);
        sc_expect("R8 foreign snoop", 1);
        lr_at(32'h40, 5'd5);
        op(sc_i(5'd6), 32'h40, 32'h7777, 1, 0, 32'h44);
        sc_expect("R8 snoop at accept", 0);
        op(lr_i(5'd5), 32'h40, 32'h0, 0, 1, 32'h40);
        sc_at(32'h40, 32'h7777, 5'd6);
        sc_expect("R8 snoop in load issue", 0);
    endtask

    task automatic t_replace;
        lr_at(32'h40, 5'd5);
        lr_at(32'h80, 5'd5);
        sc_at(32'h80, 32'h8888, 5'd6);
        sc_expect("R7 newest kept", 1);
        lr_at(32'h40, 5'd5);
        lr_at(32'h80, 5'd5);
        sc_at(32'h40, 32'h8888, 5'd6);
        sc_expect("R7 older dropped", 0);
    endtask

    task automatic t_nonev;
        lr_at(32'hF000_0040, 5'd5);
        sc_at(32'hF000_0040, 32'h9999, 5'd6);
        sc_expect("R9 non-eventual", 0);
    endtask

    task automatic t_illegal;
        lr_at(32'h40, 5'd5);
        op(enc(5'b00011, 1'b0, 1'b0, 5'd7, 3'b011, 5'd6, 7'b0101111), 32'h40, 32'hAAAA, 0, 0, 0);
        chk("R10 width illegal", {61'd0, r_ill, r_we, c_req}, 64'd4);
        op(enc(5'b00010, 1'b0, 1'b0, 5'd3, 3'b010, 5'd6, 7'b0101111), 32'h40, 32'h0, 0, 0, 0);
        chk("R10 load rs2 illegal", {61'd0, r_ill, r_we, c_req}, 64'd4);
        op(enc(5'b00011, 1'b0, 1'b0, 5'd7, 3'b010, 5'd6, 7'b0110011), 32'h40, 32'hAAAA, 0, 0, 0);
        chk("R10 opcode illegal", {61'd0, r_ill, r_we, c_req}, 64'd4);
        op(enc(5'b00001, 1'b0, 1'b0, 5'd7, 3'b010, 5'd6, 7'b0101111), 32'h40, 32'hAAAA, 0, 0, 0);
        chk("R10 funct5 illegal", {61'd0, r_ill, r_we, c_req}, 64'd4);
        sc_at(32'h40, 32'hBBBB, 5'd6);
        sc_expect("R10 reservation kept", 1);
    endtask

    task automatic t_order;
        op(enc(5'b00010, 1'b1, 1'b0, 5'd0, 3'b010, 5'd5, 7'b0101111), 32'h40, 32'h0, 0, 0, 0);
        chk("R11 acquire", {62'd0, c_aq, c_rl}, 64'd2);
        chk("R11 idle clear", {62'd0, i_aq, i_rl}, 64'd0);
        op(enc(5'b00011, 1'b0, 1'b1, 5'd7, 3'b010, 5'd6, 7'b0101111), 32'h40, 32'hCCCC, 0, 0, 0);
        chk("R11 release", {62'd0, c_aq, c_rl}, 64'd1);
        sc_expect("R11 ordered store", 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 32'h1000_0000 + i;
        bmem[16] = 32'h8000_1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load;
        t_store;
        t_granule;
        t_snoop;
        t_replace;
        t_nonev;
        t_illegal;
        t_order;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule